// File: doc/BRIEF.md
# Signed Halfword Multiply-Accumulate Unit

This block multiplies one 16-bit half of one 32-bit operand by one 16-bit half of another. Both halves are treated as signed. The product can be returned on its own, added to a 32-bit addend, or sign-extended and added to a 64-bit addend. The 64-bit addend arrives as a high word and a low word, and the 64-bit result leaves the same way. A separate select bit for each operand picks its half.

All results are registered. They appear one clock after the request strobe, together with a result-valid flag. Only the 32-bit addition can raise an overflow: when it does, the block gives a one-cycle pulse and also sets a sticky saturation flag. That flag stays set until software-side control logic clears it through a dedicated synchronous clear input. The half width is a parameter with a default of 16. A second parameter picks the multiplier variant: the synthesis operator, or an explicit shift-and-add array.

Top module: `halfmul_acc`

## Requirements
- R1: The half-select bit of an operand chooses its half. A value of 1 uses the upper half, sign-extended. A value of 0 uses the lower half, sign-extended.
- R2: Operation code 0 (plain multiply) returns the signed product of the two selected halves on `res_o`. `res_hi_o:res_lo_o` carries that product sign-extended to double width. The sticky flag is unaffected.
- R3: Operation code 1 (word accumulate) returns on `res_o` the low word of the product plus `acc_i`. The 64-bit outputs carry that word sign-extended.
- R4: Operation code 2 (long accumulate) sign-extends the product to double width and adds `{acc_hi_i, acc_lo_i}` to it. The high word of the sum goes to `res_hi_o` and the low word to `res_lo_o`. `res_o` equals `res_lo_o`.
- R5: `ovf_o` is high for exactly the one cycle after an accepted operation-code-1 request whose addition overflows as a signed word. It stays low after every other operation code.
- R6: `sat_o` is set whenever `ovf_o` is set, and it holds its value until `clr_sat_i` is sampled high. A clear in the same cycle as a setting request loses, so the flag stays set.
- R7: Outputs update on the clock edge that samples `valid_i` high, and `valid_o` is high in the following cycle. While `valid_i` is low, `res_o`, `res_lo_o` and `res_hi_o` hold and `valid_o` is low.
- R8: Operation code 3 behaves as operation code 0.
- R9: During and after reset, every output is zero.
- R10: The product of the most negative half by itself is the positive value 2^(2·HALF_W−2). In code 0 this raises no overflow or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request strobe |
| op_i | input | 2 | Operation code (0 multiply, 1 word accumulate, 2 long accumulate, 3 as 0) |
| opa_i | input | 2·HALF_W | First operand |
| opb_i | input | 2·HALF_W | Second operand |
| hi_a_i | input | 1 | Half select for first operand (1 = upper) |
| hi_b_i | input | 1 | Half select for second operand (1 = upper) |
| acc_i | input | 2·HALF_W | Word addend for code 1 |
| acc_lo_i | input | 2·HALF_W | Low word of the long addend |
| acc_hi_i | input | 2·HALF_W | High word of the long addend |
| clr_sat_i | input | 1 | Synchronous clear of the sticky flag |
| valid_o | output | 1 | Result valid |
| res_o | output | 2·HALF_W | Word result |
| res_lo_o | output | 2·HALF_W | Low word of the long result |
| res_hi_o | output | 2·HALF_W | High word of the long result |
| ovf_o | output | 1 | One-cycle overflow pulse |
| sat_o | output | 1 | Sticky saturation flag |

## Verification
The assertions check several properties on every cycle:
- an overflow pulse only ever follows an accepted word-accumulate request;
- the sticky flag rises only with a pulse, and it holds unless cleared;
- results stay still while no request is accepted;
- the extreme negative-by-negative product stays positive.

The arithmetic itself can only be shown by the bench's sweep at a 4-bit half width, with every value computed independently. The sweep covers each pairing of half values against every select combination and operation code. The directed scenarios show the behaviours that need a particular sequence: set winning over a same-cycle clear, the pulse falling after one cycle, the long form leaving the flag alone, and the reset values.

// File: rtl/hmac_pkg.sv
package hmac_pkg;
   typedef enum logic [1:0] {
      HM_MUL    = 2'd0,
      HM_ACC32  = 2'd1,
      HM_ACC64  = 2'd2,
      HM_MULALT = 2'd3
   } hm_op_e;
endpackage

// File: rtl/hmac_half_sel.sv
module hmac_half_sel #(
   parameter int HALF_W = 16,
   localparam int W = 2 * HALF_W
) (
   input  logic [W-1:0]      word_i,
   input  logic              hi_i,
   output logic [HALF_W-1:0] half_o
);
   // Upper half is taken as-is (arithmetic shift of a signed word);
   // sign extension is applied later by the multiplier.
   always_comb begin
      if (hi_i) half_o = word_i[W-1:HALF_W];
      else      half_o = word_i[HALF_W-1:0];
   end
endmodule

// File: rtl/hmac_mul.sv
module hmac_mul #(
   parameter int HALF_W    = 16,
   parameter bit ARRAY_MUL = 1'b0,
   localparam int W = 2 * HALF_W
) (
   input  logic [HALF_W-1:0] a_i,
   input  logic [HALF_W-1:0] b_i,
   output logic [W-1:0]      prod_o
);
   localparam logic [HALF_W-1:0] MIN_HALF = {1'b1, {(HALF_W-1){1'b0}}};

   logic [W-1:0] ax;
   logic [W-1:0] bx;
   assign ax = {{HALF_W{a_i[HALF_W-1]}}, a_i};
   assign bx = {{HALF_W{b_i[HALF_W-1]}}, b_i};

   generate
      if (ARRAY_MUL) begin : g_array
         logic [W-1:0] chain [0:HALF_W];
         assign chain[0] = '0;
         for (genvar k = 0; k < HALF_W; k++) begin : g_row
            logic [W-1:0] pp;
            assign pp = b_i[k] ? (ax << k) : '0;
            if (k == HALF_W - 1) begin : g_sign
               assign chain[k+1] = chain[k] - pp;
            end else begin : g_pos
               assign chain[k+1] = chain[k] + pp;
            end
         end
         assign prod_o = chain[HALF_W];
         logic unused_bx;
         assign unused_bx = ^bx;
      end else begin : g_op
         assign prod_o = $signed(ax) * $signed(bx);
      end
   endgenerate

   always_comb begin
      if (a_i == MIN_HALF && b_i == MIN_HALF)
         AST_MINMIN_POS: assert (prod_o[W-1] == 1'b0); // R10
   end
endmodule

// File: rtl/hmac_accum.sv
module hmac_accum #(
   parameter int HALF_W = 16,
   localparam int W = 2 * HALF_W
) (
   input  logic [W-1:0]   prod_i,
   input  logic [W-1:0]   acc_i,
   input  logic [2*W-1:0] acc64_i,
   output logic [W-1:0]   sum32_o,
   output logic           ovf32_o,
   output logic [2*W-1:0] sum64_o
);
   assign sum32_o = prod_i + acc_i;
   assign ovf32_o = (prod_i[W-1] == acc_i[W-1]) && (sum32_o[W-1] != prod_i[W-1]);
   assign sum64_o = {{W{prod_i[W-1]}}, prod_i} + acc64_i;
endmodule

// File: rtl/halfmul_acc.sv
module halfmul_acc #(
   parameter int HALF_W    = 16,
   parameter bit ARRAY_MUL = 1'b0,
   localparam int W = 2 * HALF_W
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         valid_i,
   input  logic [1:0]   op_i,
   input  logic [W-1:0] opa_i,
   input  logic [W-1:0] opb_i,
   input  logic         hi_a_i,
   input  logic         hi_b_i,
   input  logic [W-1:0] acc_i,
   input  logic [W-1:0] acc_lo_i,
   input  logic [W-1:0] acc_hi_i,
   input  logic         clr_sat_i,
   output logic         valid_o,
   output logic [W-1:0] res_o,
   output logic [W-1:0] res_lo_o,
   output logic [W-1:0] res_hi_o,
   output logic         ovf_o,
   output logic         sat_o
);
   import hmac_pkg::*;

   generate
      if (HALF_W < 2) begin : g_bad_width
         $error("halfmul_acc: HALF_W must be at least 2");
      end
   endgenerate

   logic [HALF_W-1:0] half_a, half_b;
   logic [W-1:0]      prod;
   logic [W-1:0]      sum32;
   logic              ovf32;
   logic [2*W-1:0]    sum64;
   hm_op_e            op;

   assign op = hm_op_e'(op_i);

   hmac_half_sel #(.HALF_W(HALF_W)) i_sel_a (.word_i(opa_i), .hi_i(hi_a_i), .half_o(half_a));
   hmac_half_sel #(.HALF_W(HALF_W)) i_sel_b (.word_i(opb_i), .hi_i(hi_b_i), .half_o(half_b));

   hmac_mul #(.HALF_W(HALF_W), .ARRAY_MUL(ARRAY_MUL)) i_mul (
      .a_i(half_a), .b_i(half_b), .prod_o(prod)
   );

   hmac_accum #(.HALF_W(HALF_W)) i_acc (
      .prod_i(prod), .acc_i(acc_i), .acc64_i({acc_hi_i, acc_lo_i}),
      .sum32_o(sum32), .ovf32_o(ovf32), .sum64_o(sum64)
   );

   logic [2*W-1:0] res_d;
   logic           set_d;

   always_comb begin
      set_d = 1'b0;
      unique case (op)
         HM_ACC32: begin
            res_d = {{W{sum32[W-1]}}, sum32};
            set_d = ovf32;
         end
         HM_ACC64: res_d = sum64;
         default:  res_d = {{W{prod[W-1]}}, prod};
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_o  <= 1'b0;
         res_o    <= '0;
         res_lo_o <= '0;
         res_hi_o <= '0;
         ovf_o    <= 1'b0;
      end else begin
         valid_o <= valid_i;
         ovf_o   <= valid_i && set_d;
         if (valid_i) begin
            res_o    <= res_d[W-1:0];
            res_lo_o <= res_d[W-1:0];
            res_hi_o <= res_d[2*W-1:W];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                sat_o <= 1'b0;
      else if (valid_i && set_d)  sat_o <= 1'b1;
      else if (clr_sat_i)         sat_o <= 1'b0;
   end

   AST_OVF_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_o |-> ($past(valid_i) && $past(op_i) == 2'd1)); // R5
   AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_o |-> sat_o); // R6
   AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(sat_o) && !$past(clr_sat_i)) |-> sat_o); // R6
   AST_SAT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sat_o) |-> ovf_o); // R6
   AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(valid_o) |-> $past(valid_i)); // R7
   AST_RES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(valid_i) |-> ($stable(res_o) && $stable(res_hi_o))); // R7
endmodule

// File: tb/test_halfmul_acc.sv
module test_halfmul_acc;
   localparam int HW = 4;
   localparam int W  = 2 * HW;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         valid = 1'b0;
   logic [1:0]   op = '0;
   logic [W-1:0] opa = '0, opb = '0, acc = '0, acc_lo = '0, acc_hi = '0;
   logic         hi_a = 1'b0, hi_b = 1'b0, clr = 1'b0;
   logic         valid_o, ovf_o, sat_o;
   logic [W-1:0] res_o, res_lo_o, res_hi_o;

   int n_chk = 0, n_bad = 0;
   bit done = 0;
   bit exp_sat = 0;
   logic [W-1:0] last32, last_lo, last_hi;

   always #10 clk = ~clk;

   halfmul_acc #(.HALF_W(HW), .ARRAY_MUL(1'b1)) i_halfmul_acc (
      .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
      .opa_i(opa), .opb_i(opb), .hi_a_i(hi_a), .hi_b_i(hi_b),
      .acc_i(acc), .acc_lo_i(acc_lo), .acc_hi_i(acc_hi), .clr_sat_i(clr),
      .valid_o(valid_o), .res_o(res_o), .res_lo_o(res_lo_o), .res_hi_o(res_hi_o),
      .ovf_o(ovf_o), .sat_o(sat_o)
   );

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic int hsel(logic [W-1:0] w, bit hi);
      return hi ? int'($signed(w[W-1:HW])) : int'($signed(w[HW-1:0]));
   endfunction

   task automatic run_vec(logic [1:0] o, logic [W-1:0] a, logic [W-1:0] b, bit ha, bit hb,
                          logic [W-1:0] ac, logic [2*W-1:0] ac64, bit cl);
      int p, s;
      longint s64;
      logic [W-1:0] e32;
      logic [2*W-1:0] e64;
      bit eo;
      string tag;
      p  = hsel(a, ha) * hsel(b, hb);
      eo = 0;
      case (o)
         2'd1: begin
            s   = p + int'($signed(ac));
            e32 = s[W-1:0];
            eo  = (s > 127) || (s < -128);
            e64 = {{W{e32[W-1]}}, e32};
            tag = "R3";
         end
         2'd2: begin
            s64 = longint'(p) + longint'($signed(ac64));
            e64 = s64[2*W-1:0];
            e32 = e64[W-1:0];
            tag = "R4";
         end
         default: begin
            e32 = p[W-1:0];
            e64 = {{W{e32[W-1]}}, e32};
            tag = (o == 2'd3) ? "R8" : "R1 R2";
         end
      endcase
      if (eo) exp_sat = 1;
      else if (cl) exp_sat = 0;
      op = o; opa = a; opb = b; hi_a = ha; hi_b = hb; acc = ac;
      acc_lo = ac64[W-1:0]; acc_hi = ac64[2*W-1:W]; clr = cl; valid = 1'b1;
      @(negedge clk);
      chk(tag, 64'(res_o), 64'(e32));
      chk(tag, 64'({res_hi_o, res_lo_o}), 64'(e64));
      chk("R5", 64'(ovf_o), 64'(eo));
      chk("R6", 64'(sat_o), 64'(exp_sat));
      chk("R7", 64'(valid_o), 64'd1);
      last32 = e32; last_lo = e64[W-1:0]; last_hi = e64[2*W-1:W];
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9", 64'({valid_o, ovf_o, sat_o}), 64'd0);
      chk("R9", 64'({res_o, res_lo_o, res_hi_o}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9", 64'({res_o, valid_o, sat_o}), 64'd0);

      // R10: most negative times itself, upper halves
      run_vec(2'd0, 8'h80, 8'h85, 1, 1, 8'h00, 16'h0, 0);
      chk("R10", 64'(res_o), 64'h40);

      // R7: hold with valid low
      valid = 1'b0; opa = 8'h33; opb = 8'h77; op = 2'd1;
      @(negedge clk);
      chk("R7", 64'(valid_o), 64'd0);
      chk("R7", 64'({res_o, res_lo_o, res_hi_o}), 64'({last32, last_lo, last_hi}));

      // R5/R6: word accumulate overflow, 64 + 64
      run_vec(2'd1, 8'h80, 8'h80, 1, 1, 8'h40, 16'h0, 0);
      valid = 1'b0;
      @(negedge clk);
      chk("R5", 64'(ovf_o), 64'd0);
      chk("R6", 64'(sat_o), 64'd1);
      // no overflow at the boundary: 64 + 63
      run_vec(2'd1, 8'h80, 8'h80, 1, 1, 8'h3F, 16'h0, 0);
      // R6 clear
      valid = 1'b0; clr = 1'b1;
      @(negedge clk);
      clr = 1'b0; exp_sat = 0;
      chk("R6", 64'(sat_o), 64'd0);
      // R6 set wins over same-cycle clear
      run_vec(2'd1, 8'h08, 8'h08, 0, 0, 8'h40, 16'h0, 1);
      valid = 1'b0; clr = 1'b1;
      @(negedge clk);
      clr = 1'b0; exp_sat = 0;
      // R4/R5: long accumulate carrying across words leaves the flag alone
      run_vec(2'd2, 8'h80, 8'h80, 1, 1, 8'h00, 16'h7FC0, 0);
      run_vec(2'd2, 8'h07, 8'h90, 0, 1, 8'h00, 16'h0005, 0);
      // R2: plain multiply with large values
      run_vec(2'd0, 8'h07, 8'h70, 0, 1, 8'h7F, 16'h0, 0);

      // near-exhaustive sweep
      for (int x = 0; x < 16; x++)
         for (int y = 0; y < 16; y++)
            for (int s = 0; s < 4; s++)
               for (int o = 0; o < 4; o++) begin
                  logic [3:0] xa, ya, xs;
                  xa = x[3:0]; ya = y[3:0]; xs = xa + s[3:0];
                  run_vec(o[1:0], {xa, ~ya}, {ya, xs}, s[1], s[0],
                          8'((x * 37 + y * 11 + s * 5 + o) & 255),
                          16'((x * 4099 + y * 257 + s * 31) & 65535), 0);
               end

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule